// File: doc/BRIEF.md
# Write-back, write-allocate second-level line cache controller

This block is a direct-mapped second-level cache controller that holds whole 32-byte lines together with a valid bit and a dirty bit for each line. A client above it issues either a line read or a partial-line write with per-byte enables. Each request is accepted on a valid/ready handshake. The controller returns the full line on a one-cycle response pulse a fixed number of cycles later, and that number differs between hits and misses. Below the controller, main memory is reached through a line-wide request/acknowledge port that carries 256 bits per transfer.

Writes only touch the cached copy. Memory learns about modified data when such a line is displaced. On a miss, the line being displaced is copied into a one-entry victim buffer and the replacement line is read from memory first. Only after that line is installed is the parked victim written out, and only if it was dirty. Write misses allocate: the fetched line has the write bytes merged in and is installed dirty. One request is handled at a time.

The number of lines is a parameter. A 16-bit index gives the full 64K-line size, and the default is a smaller instance.

Top module: `l2wb_cache`

## Requirements
- R1: After reset (asynchronous, active low) every line is invalid, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0. The first access to any line after a reset is therefore a miss.
- R2: A read hit returns the stored line on `rsp_data` with `rsp_valid` high for exactly one cycle. That cycle begins HIT_LAT rising edges after the accepting edge, and the hit causes no memory transfer.
- R3: A read miss issues one memory read (`mem_we`=0) of the requested line address and installs the returned line clean. If memory acknowledges in time, the response carries that line MISS_LAT edges after the accepting edge.
- R4: A write hit replaces byte i of the line (bits 8i+7..8i) with byte i of `req_wdata` wherever `req_be[i]` is 1. It keeps the other bytes, marks the line dirty, returns the merged line and performs no memory transfer.
- R5: A write miss fetches the line from memory, merges the enabled bytes as in R4, installs the result dirty and returns the merged line after MISS_LAT edges.
- R6: Memory is written only when a miss displaces a valid dirty line. A clean or invalid victim produces no memory write.
- R7: When a dirty line is displaced, the memory read of the new line comes first. Once the new line is installed, exactly one memory write follows, carrying the victim's line address ({old tag, index}) and its full cached contents.
- R8: After a request is accepted, `req_ready` stays 0 until the response has been delivered and any victim write has been acknowledged.
- R9: While `mem_req` is high and `mem_ack` has not arrived, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R10: The index is the low IDX_W bits of the line address and the tag is the remaining high bits. Two addresses with equal index and different tags displace each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered by the client |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = partial-line write, 0 = line read |
| req_addr | input | ADDR_W | Line address (index in low bits) |
| req_wdata | input | LINE_BYTES*8 | Write data, byte i in bits 8i+7..8i |
| req_be | input | LINE_BYTES | Per-byte write enables |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | LINE_BYTES*8 | Line contents after the request |
| mem_req | output | 1 | Memory transfer request, held until acknowledged |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W | Line address of the transfer |
| mem_wdata | output | LINE_BYTES*8 | Line written to memory |
| mem_ack | input | 1 | One-cycle acknowledge from memory |
| mem_rdata | input | LINE_BYTES*8 | Line returned with the acknowledge of a read |

## Verification
The case hardest to reach from the ports is a miss that displaces a line dirtied earlier. Only in that case do the deferred victim write and its ordering behind the fill appear. To produce it, the stimulus table first reads or writes a line, then dirties it with a write hit or a write miss, and then touches a different tag with the same index. A bench-side memory model logs every transfer in order, so both the order and the victim's data can be compared. A later miss back to the displaced address shows whether memory received the merged bytes. A reset in the middle of the run, followed by access to a line that was valid before the reset, shows that the valid bits were cleared.

// File: rtl/l2wb_pkg.sv
package l2wb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_LOOKUP    = 3'd1,
      ST_FETCH     = 3'd2,
      ST_INSTALL   = 3'd3,
      ST_WRITEBACK = 3'd4
   } l2_state_e;

endpackage

// File: rtl/l2wb_merge.sv
module l2wb_merge #(
   parameter int BYTES = 32
) (
   input  logic [BYTES*8-1:0] base_line,
   input  logic [BYTES*8-1:0] new_line,
   input  logic [BYTES-1:0]   byte_en,
   output logic [BYTES*8-1:0] merged_line
);

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign merged_line[b*8 +: 8] = byte_en[b] ? new_line[b*8 +: 8]
                                                : base_line[b*8 +: 8];
   end

endmodule

// File: rtl/l2wb_store.sv
module l2wb_store #(
   parameter int IDX_W  = 6,
   parameter int TAG_W  = 14,
   parameter int LINE_W = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic              wr_dirty,
   input  logic [LINE_W-1:0] wr_line
);

   localparam int LINES = 1 << IDX_W;

   logic [LINES-1:0]  valid_q;
   logic [LINES-1:0]  dirty_q;
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [LINE_W-1:0] line_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
         dirty_q[wr_idx] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         line_q[wr_idx] <= wr_line;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_line  = line_q[rd_idx];

endmodule

// File: rtl/l2wb_timer.sv
module l2wb_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] start_val,
   input  logic             reload,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             data_ok,
   output logic             fire,
   output logic             busy
);

   logic [CNT_W-1:0] cnt_q;

   assign fire = busy && (cnt_q == '0) && data_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= start_val;
      end else if (reload) begin
         cnt_q <= reload_val;
      end else if (busy) begin
         if (fire)
            busy <= 1'b0;
         else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/l2wb_cache.sv
module l2wb_cache
   import l2wb_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int IDX_W      = 6,
   parameter int LINE_BYTES = 32,
   parameter int HIT_LAT    = 10,
   parameter int MISS_LAT   = 36
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_write,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [LINE_BYTES*8-1:0] req_wdata,
   input  logic [LINE_BYTES-1:0]   req_be,
   output logic                    rsp_valid,
   output logic [LINE_BYTES*8-1:0] rsp_data,
   output logic                    mem_req,
   output logic                    mem_we,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [LINE_BYTES*8-1:0] mem_wdata,
   input  logic                    mem_ack,
   input  logic [LINE_BYTES*8-1:0] mem_rdata
);

   localparam int LINE_W = LINE_BYTES * 8;
   localparam int TAG_W  = ADDR_W - IDX_W;
   localparam int CNT_W  = $clog2(MISS_LAT + 1);

   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
      $error("l2wb_cache: IDX_W must be in 1..ADDR_W-1");
   end
   if (HIT_LAT < 2) begin : g_bad_hit
      $error("l2wb_cache: HIT_LAT must be at least 2");
   end
   if (MISS_LAT <= HIT_LAT) begin : g_bad_miss
      $error("l2wb_cache: MISS_LAT must exceed HIT_LAT");
   end
   if (LINE_BYTES < 1) begin : g_bad_line
      $error("l2wb_cache: LINE_BYTES must be positive");
   end

   l2_state_e         state;
   logic              op_we;
   logic [ADDR_W-1:0] op_addr;
   logic [LINE_W-1:0] op_wdata;
   logic [LINE_BYTES-1:0] op_be;
   logic [IDX_W-1:0]  op_idx;
   logic [TAG_W-1:0]  op_tag;

   logic              vb_dirty;
   logic [ADDR_W-1:0] vb_addr;
   logic [LINE_W-1:0] vb_data;
   logic [LINE_W-1:0] fill_q;
   logic [LINE_W-1:0] rsp_q;
   logic              data_ok;

   logic              rd_valid;
   logic              rd_dirty;
   logic [TAG_W-1:0]  rd_tag;
   logic [LINE_W-1:0] rd_line;
   logic              hit;
   logic              accept;
   logic              busy;
   logic              st_wr_en;
   logic [LINE_W-1:0] merge_base;
   logic [LINE_W-1:0] merged;
   logic [LINE_BYTES-1:0] eff_be;

   assign op_idx = op_addr[IDX_W-1:0];
   assign op_tag = op_addr[ADDR_W-1:IDX_W];
   assign hit    = rd_valid && (rd_tag == op_tag);
   assign accept = req_valid && req_ready;

   assign req_ready = (state == ST_IDLE) && !busy;

   assign eff_be     = op_we ? op_be : '0;
   assign merge_base = (state == ST_INSTALL) ? fill_q : rd_line;
   assign st_wr_en   = (state == ST_INSTALL) ||
                       ((state == ST_LOOKUP) && hit && op_we);

   l2wb_store #(
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .LINE_W (LINE_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (op_idx),
      .rd_valid (rd_valid),
      .rd_dirty (rd_dirty),
      .rd_tag   (rd_tag),
      .rd_line  (rd_line),
      .wr_en    (st_wr_en),
      .wr_idx   (op_idx),
      .wr_tag   (op_tag),
      .wr_dirty (op_we),
      .wr_line  (merged)
   );

   l2wb_merge #(
      .BYTES (LINE_BYTES)
   ) u_merge (
      .base_line   (merge_base),
      .new_line    (op_wdata),
      .byte_en     (eff_be),
      .merged_line (merged)
   );

   l2wb_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .start_val  (CNT_W'(HIT_LAT)),
      .reload     ((state == ST_LOOKUP) && !hit),
      .reload_val (CNT_W'(MISS_LAT - 1)),
      .data_ok    (data_ok),
      .fire       (rsp_valid),
      .busy       (busy)
   );

   assign rsp_data  = rsp_q;
   assign mem_req   = (state == ST_FETCH) || (state == ST_WRITEBACK);
   assign mem_we    = (state == ST_WRITEBACK);
   assign mem_addr  = (state == ST_WRITEBACK) ? vb_addr : op_addr;
   assign mem_wdata = vb_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         op_we    <= 1'b0;
         op_addr  <= '0;
         op_wdata <= '0;
         op_be    <= '0;
         vb_dirty <= 1'b0;
         vb_addr  <= '0;
         vb_data  <= '0;
         fill_q   <= '0;
         rsp_q    <= '0;
         data_ok  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  op_we    <= req_write;
                  op_addr  <= req_addr;
                  op_wdata <= req_wdata;
                  op_be    <= req_be;
                  data_ok  <= 1'b0;
                  state    <= ST_LOOKUP;
               end
            end
            ST_LOOKUP: begin
               if (hit) begin
                  rsp_q   <= merged;
                  data_ok <= 1'b1;
                  state   <= ST_IDLE;
               end else begin
                  vb_dirty <= rd_valid && rd_dirty;
                  vb_addr  <= {rd_tag, op_idx};
                  vb_data  <= rd_line;
                  state    <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  fill_q <= mem_rdata;
                  state  <= ST_INSTALL;
               end
            end
            ST_INSTALL: begin
               rsp_q   <= merged;
               data_ok <= 1'b1;
               state   <= vb_dirty ? ST_WRITEBACK : ST_IDLE;
            end
            ST_WRITEBACK: begin
               if (mem_ack) begin
                  vb_dirty <= 1'b0;
                  state    <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/l2wb_chk.sv
module l2wb_chk
   import l2wb_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int LINE_W = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [LINE_W-1:0] mem_wdata,
   input logic              vb_dirty,
   input logic [2:0]        st
);

   // R9
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                 $stable(mem_addr) && $stable(mem_wdata)));

   // R7
   wb_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req && mem_we) |-> $past(st) == 3'(ST_INSTALL));

   // R6
   wb_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> vb_dirty);

   // R8
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R8
   victim_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vb_dirty |-> !req_ready);

   // R2
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

bind l2wb_cache l2wb_chk #(
   .ADDR_W (ADDR_W),
   .LINE_W (LINE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .vb_dirty  (vb_dirty),
   .st        (state)
);

// File: tb/sim_l2wb_cache.sv
module sim_l2wb_cache;

   localparam int AW  = 20;
   localparam int IW  = 6;
   localparam int LB  = 32;
   localparam int LW  = LB * 8;
   localparam int HL  = 10;
   localparam int ML  = 36;
   localparam int ACK_DLY = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_wdata = '0;
   logic [LB-1:0] req_be = '0;
   logic          rsp_valid;
   logic [LW-1:0] rsp_data;
   logic          mem_req;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [LW-1:0] mem_wdata;
   logic          mem_ack = 1'b0;
   logic [LW-1:0] mem_rdata = '0;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   l2wb_cache #(
      .ADDR_W (AW), .IDX_W (IW), .LINE_BYTES (LB),
      .HIT_LAT (HL), .MISS_LAT (ML)
   ) u0 (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata), .req_be (req_be),
      .rsp_valid (rsp_valid), .rsp_data (rsp_data),
      .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_ack (mem_ack), .mem_rdata (mem_rdata)
   );

   function automatic logic [LW-1:0] pat(logic [AW-1:0] a);
      logic [LW-1:0] r;
      for (int i = 0; i < LB; i++)
         r[i*8 +: 8] = a[7:0] ^ 8'(i * 37) ^ a[15:8] ^ {4'h0, a[19:16]};
      return r;
   endfunction

   function automatic logic [LW-1:0] seed_line(logic [7:0] s);
      logic [LW-1:0] r;
      for (int i = 0; i < LB; i++) r[i*8 +: 8] = s + 8'(i);
      return r;
   endfunction

   function automatic logic [LW-1:0] mrg(logic [LW-1:0] b, logic [LW-1:0] w,
                                        logic [LB-1:0] e);
      logic [LW-1:0] r;
      for (int i = 0; i < LB; i++) r[i*8 +: 8] = e[i] ? w[i*8 +: 8] : b[i*8 +: 8];
      return r;
   endfunction

   // memory model with an ordered log of transfers
   logic [LW-1:0] backing [logic [AW-1:0]];
   int            dly = 0;
   int            log_n = 0;
   logic          log_we   [8];
   logic [AW-1:0] log_addr [8];
   logic [LW-1:0] log_data [8];
   logic [AW-1:0] held_addr;
   logic          held_we;
   bit            holding = 0;

   task automatic check(bit ok, string req, logic [LW-1:0] act, logic [LW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
            holding = 0;
         end else if (mem_req && rst_n) begin
            if (holding)
               check(held_addr == mem_addr && held_we == mem_we, "R9 hold",
                     LW'({mem_we, mem_addr}), LW'({held_we, held_addr}));
            held_addr = mem_addr;
            held_we   = mem_we;
            holding   = 1;
            if (dly == ACK_DLY) begin
               dly = 0;
               if (log_n < 8) begin
                  log_we[log_n]   = mem_we;
                  log_addr[log_n] = mem_addr;
                  log_data[log_n] = mem_wdata;
               end
               log_n++;
               if (mem_we) backing[mem_addr] = mem_wdata;
               else mem_rdata = backing.exists(mem_addr) ? backing[mem_addr] : pat(mem_addr);
               mem_ack = 1'b1;
            end else begin
               dly++;
            end
         end
      end
   end

   // reference model built from the requirements
   logic          ref_valid [1<<IW];
   logic          ref_dirty [1<<IW];
   logic [AW-IW-1:0] ref_tag [1<<IW];
   logic [LW-1:0] ref_line  [1<<IW];
   logic [LW-1:0] ref_back  [logic [AW-1:0]];

   task automatic ref_clear();
      for (int i = 0; i < (1<<IW); i++) begin
         ref_valid[i] = 1'b0;
         ref_dirty[i] = 1'b0;
      end
   endtask

   typedef struct packed {
      logic          we;
      logic [AW-1:0] addr;
      logic [7:0]    seed;
      logic [LB-1:0] be;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 20'h00005, 8'h00, 32'h0000_0000},  // R3 compulsory read miss
      '{1'b0, 20'h00005, 8'h00, 32'h0000_0000},  // R2 read hit
      '{1'b1, 20'h00005, 8'hA0, 32'h0000_000F},  // R4 write hit
      '{1'b0, 20'h00005, 8'h00, 32'h0000_0000},  // R4 merged bytes visible
      '{1'b0, 20'h00045, 8'h00, 32'h0000_0000},  // R7 R10 dirty victim
      '{1'b0, 20'h00005, 8'h00, 32'h0000_0000},  // R6 clean victim, memory updated
      '{1'b1, 20'h00107, 8'h33, 32'hF0F0_0000},  // R5 write miss allocate
      '{1'b1, 20'h00207, 8'h5C, 32'h0000_FF00},  // R5 R7 write miss, dirty victim
      '{1'b0, 20'h00207, 8'h00, 32'h0000_0000},  // R2 hit after allocate
      '{1'b1, 20'h0003F, 8'hC1, 32'hFFFF_FFFF},  // R5 full-line write miss
      '{1'b0, 20'h0007F, 8'h00, 32'h0000_0000}   // R7 displace it
   };

   task automatic run_op(logic we, logic [AW-1:0] addr, logic [LW-1:0] wd,
                         logic [LB-1:0] be);
      logic [IW-1:0]    idx = addr[IW-1:0];
      logic [AW-IW-1:0] tg  = addr[AW-1:IW];
      bit               hit = ref_valid[idx] && ref_tag[idx] == tg;
      bit               vdirty = !hit && ref_valid[idx] && ref_dirty[idx];
      logic [AW-1:0]    vaddr = {ref_tag[idx], idx};
      logic [LW-1:0]    vline = ref_line[idx];
      logic [LW-1:0]    base;
      logic [LW-1:0]    exp_line;
      int               exp_lat = hit ? HL : ML;
      int               e = 0;
      if (hit) base = ref_line[idx];
      else base = ref_back.exists(addr) ? ref_back[addr] : pat(addr);
      exp_line = we ? mrg(base, wd, be) : base;
      if (vdirty) ref_back[vaddr] = vline;
      ref_line[idx]  = exp_line;
      ref_dirty[idx] = hit ? (ref_dirty[idx] | we) : we;
      ref_valid[idx] = 1'b1;
      ref_tag[idx]   = tg;

      while (!req_ready) @(negedge clk);
      log_n = 0;
      req_valid = 1'b1; req_write = we; req_addr = addr; req_wdata = wd; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      // R8 blocked right after acceptance
      check(req_ready == 1'b0, "R8 ready low when busy", LW'(req_ready), LW'(0));
      while (!rsp_valid && e < 400) begin
         @(negedge clk);
         e++;
      end
      check(e == exp_lat, hit ? "R2 hit latency" : "R3 miss latency", LW'(e), LW'(exp_lat));
      check(rsp_data == exp_line, we ? "R4/R5 merged line" : "R2/R3 line data",
            rsp_data, exp_line);
      e = 0;
      while (!req_ready && e < 400) begin
         @(negedge clk);
         e++;
      end
      // transfer log: R6 count, R7 order and contents
      check(log_n == (hit ? 0 : (vdirty ? 2 : 1)), "R6 transfer count",
            LW'(log_n), LW'(hit ? 0 : (vdirty ? 2 : 1)));
      if (!hit && log_n >= 1)
         check(log_we[0] == 1'b0 && log_addr[0] == addr, "R3 fill read first",
               LW'({log_we[0], log_addr[0]}), LW'({1'b0, addr}));
      if (vdirty && log_n >= 2)
         check(log_we[1] == 1'b1 && log_addr[1] == vaddr && log_data[1] == vline,
               "R7 victim write", log_data[1], vline);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      ref_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready == 1'b1, "R1 ready after reset", LW'(req_ready), LW'(1));
      check(rsp_valid == 1'b0, "R1 no response after reset", LW'(rsp_valid), LW'(0));
      check(mem_req == 1'b0, "R1 no memory request after reset", LW'(mem_req), LW'(0));

      for (int v = 0; v < NV; v++)
         run_op(VECS[v].we, VECS[v].addr, seed_line(VECS[v].seed), VECS[v].be);

      // R1 reset invalidates a line that was valid (0x00207)
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      ref_clear();
      @(negedge clk);
      check(req_ready == 1'b1, "R1 ready after second reset", LW'(req_ready), LW'(1));
      run_op(1'b0, 20'h00207, '0, '0);
      // R10 same index, other tag, then back: clean victims only
      run_op(1'b0, 20'h00307, '0, '0);
      run_op(1'b0, 20'h00207, '0, '0);
      // R4 write hit with scattered enables, then displace it
      run_op(1'b1, 20'h00207, seed_line(8'h91), 32'h8000_0101);
      run_op(1'b0, 20'h00007, '0, '0);
      run_op(1'b0, 20'h00207, '0, '0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule